// File: doc/BRIEF.md
# Integer Execute Stage

This block is the arithmetic stage of a small in-order integer pipeline. Each cycle it may accept one decoded operation. The operation is described by a 2-bit class, a 5-bit operation selector, two register operands, a 5-bit shift amount, a 16-bit immediate and the address of the current instruction. One clock later it returns a 64-bit result together with a valid strobe.

The operations cover register-to-register arithmetic, logic, shifts, comparisons, multiply and divide. They also cover immediate arithmetic, logic and comparisons, the effective-address sums used by loads and stores, branch condition flags, and return-address values for calls.

Multiply and divide place their full output on the single 64-bit result. Narrow results occupy bits 31:0 with zeros above. Additions and subtractions wrap and never flag an overflow. The only error the block reports is an operation class it does not know.

Top module: `exu_top`

## Requirements
- R1: `outValid` is high exactly in the cycle after a cycle with `inValid` high. While `inValid` is low, `result` and `errFlag` keep their values. Reset clears `outValid`, `result` and `errFlag` to zero.
- R2: In class 0, selectors 0 and 1 give opA+opB, and selectors 2 and 3 give opB−opA. All four wrap modulo 2^32, never set `errFlag`, and put their result in bits 31:0 with bits 63:32 zero.
- R3: Class 0 selectors 4 (left), 6 (right logical) and 8 (right arithmetic) shift opA by `shamt`. Selectors 5, 7 and 9 perform the same shifts using only opB[4:0] as the amount.
- R4: The right arithmetic shifts (class 0, selectors 8 and 9) fill the vacated bits with copies of opA[31]. The right logical shifts (selectors 6 and 7) fill them with zeros.
- R5: Class 0 selectors 10, 11, 12 and 13 give bitwise AND, OR, XOR and NOR of opA and opB.
- R6: Class 0 selector 14 gives 1 when opA < opB as signed numbers and 0 otherwise; selector 15 makes the same comparison unsigned. Class 1 selector 2 compares opA as signed against the sign-extended immediate, and selector 3 compares opA as unsigned against the zero-extended immediate.
- R7: Class 0 selector 16 gives the signed 64-bit product of opA and opB, and selector 17 gives the unsigned 64-bit product.
- R8: Class 0 selectors 18 (signed) and 19 (unsigned) divide opA by opB. The remainder goes to bits 63:32 and the quotient to bits 31:0. If opB is zero, the result is all zeros.
- R9: Class 1 selectors 0, 1 and 8 (load address) give opA plus the sign-extended immediate. Selector 9 (store address) gives opB plus the sign-extended immediate.
- R10: Class 1 selectors 4, 5 and 6 give the AND, OR and XOR of opA[15:0] with the immediate, with bits 63:16 zero. Selector 7 gives the immediate in bits 31:16 and zeros in bits 15:0.
- R11: Class 1 selector 10 gives 1 when opA equals opB, selector 11 gives 1 when they differ, and selector 12 gives 1 when opA is negative as a signed value. Each gives 0 otherwise.
- R12: Class 2 selector 0 and class 0 selector 20 give `pcIn`+2, wrapping modulo 2^32.
- R13: Class 3 sets `errFlag` and gives a zero result. Any other class clears `errFlag`. A selector not listed above for class 0, 1 or 2 gives a zero result without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An operation is presented this cycle |
| instrClass | input | 2 | 0 register form, 1 immediate form, 2 jump form, 3 unknown |
| opSel | input | 5 | Operation selector within the class |
| opA | input | 32 | First register operand |
| opB | input | 32 | Second register operand |
| shamt | input | 5 | Fixed shift amount |
| imm | input | 16 | Immediate field |
| pcIn | input | 32 | Address of the current instruction |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| result | output | 64 | Computed value |
| errFlag | output | 1 | Unknown class seen on the last accepted operation |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 16-bit immediate, a 5-bit shift amount and a link increment of 2. These defaults bring within reach the wrap of a sum at 2^32, the difference between sign and zero extension of an immediate, the 5-bit masking of variable shift amounts, and the packing of a 32-bit remainder above the quotient. They also make the full 64-bit product observable, including the sign extension of a negative signed product. Division by zero, a branch condition on each polarity, and the wrap of the link address at the top of the address space are all exercised.

// File: rtl/exu_pkg.sv
package exu_pkg;

  // Operation classes
  localparam logic [1:0] CLS_REG = 2'd0;
  localparam logic [1:0] CLS_IMM = 2'd1;
  localparam logic [1:0] CLS_JMP = 2'd2;
  localparam logic [1:0] CLS_BAD = 2'd3;

  // Register-form selectors
  localparam logic [4:0] OP_ADD   = 5'd0;
  localparam logic [4:0] OP_ADDU  = 5'd1;
  localparam logic [4:0] OP_SUB   = 5'd2;
  localparam logic [4:0] OP_SUBU  = 5'd3;
  localparam logic [4:0] OP_SLL   = 5'd4;
  localparam logic [4:0] OP_SLLV  = 5'd5;
  localparam logic [4:0] OP_SRL   = 5'd6;
  localparam logic [4:0] OP_SRLV  = 5'd7;
  localparam logic [4:0] OP_SRA   = 5'd8;
  localparam logic [4:0] OP_SRAV  = 5'd9;
  localparam logic [4:0] OP_AND   = 5'd10;
  localparam logic [4:0] OP_OR    = 5'd11;
  localparam logic [4:0] OP_XOR   = 5'd12;
  localparam logic [4:0] OP_NOR   = 5'd13;
  localparam logic [4:0] OP_SLT   = 5'd14;
  localparam logic [4:0] OP_SLTU  = 5'd15;
  localparam logic [4:0] OP_MULT  = 5'd16;
  localparam logic [4:0] OP_MULTU = 5'd17;
  localparam logic [4:0] OP_DIV   = 5'd18;
  localparam logic [4:0] OP_DIVU  = 5'd19;
  localparam logic [4:0] OP_JALR  = 5'd20;

  // Immediate-form selectors
  localparam logic [4:0] OPI_ADDI  = 5'd0;
  localparam logic [4:0] OPI_ADDIU = 5'd1;
  localparam logic [4:0] OPI_SLTI  = 5'd2;
  localparam logic [4:0] OPI_SLTIU = 5'd3;
  localparam logic [4:0] OPI_ANDI  = 5'd4;
  localparam logic [4:0] OPI_ORI   = 5'd5;
  localparam logic [4:0] OPI_XORI  = 5'd6;
  localparam logic [4:0] OPI_LUI   = 5'd7;
  localparam logic [4:0] OPI_LOAD  = 5'd8;
  localparam logic [4:0] OPI_STORE = 5'd9;
  localparam logic [4:0] OPI_BEQ   = 5'd10;
  localparam logic [4:0] OPI_BNE   = 5'd11;
  localparam logic [4:0] OPI_BLTZ  = 5'd12;

  // Jump-form selectors
  localparam logic [4:0] OPJ_CALL = 5'd0;

  typedef enum logic [4:0] {
    FN_ZERO, FN_ADD, FN_SUB, FN_SLL, FN_SRL, FN_SRA,
    FN_AND, FN_OR, FN_XOR, FN_NOR, FN_SLT, FN_SLTU,
    FN_MULS, FN_MULU, FN_DIVS, FN_DIVU, FN_LINK, FN_LUI,
    FN_EQ, FN_NE, FN_LTZ
  } aluFn_e;

  typedef enum logic [1:0] {SA_REGA, SA_REGB, SA_LOWA} srcA_e;
  typedef enum logic [1:0] {SB_REGB, SB_SEXT, SB_ZEXT} srcB_e;

  typedef struct packed {
    aluFn_e fn;
    srcA_e  srcA;
    srcB_e  srcB;
    logic   varShift;
    logic   illegal;
  } ctrlStrobe_t;

endpackage

// File: rtl/exu_ctrl.sv
module exu_ctrl
  import exu_pkg::*;
(
  input  logic [1:0]  instrClass,
  input  logic [4:0]  opSel,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.fn       = FN_ZERO;
    strobe.srcA     = SA_REGA;
    strobe.srcB     = SB_REGB;
    strobe.varShift = 1'b0;
    strobe.illegal  = 1'b0;
    case (instrClass)
      CLS_REG: begin
        case (opSel)
          OP_ADD, OP_ADDU: strobe.fn = FN_ADD;
          OP_SUB, OP_SUBU: strobe.fn = FN_SUB;
          OP_SLL:  strobe.fn = FN_SLL;
          OP_SRL:  strobe.fn = FN_SRL;
          OP_SRA:  strobe.fn = FN_SRA;
          OP_SLLV: begin strobe.fn = FN_SLL; strobe.varShift = 1'b1; end
          OP_SRLV: begin strobe.fn = FN_SRL; strobe.varShift = 1'b1; end
          OP_SRAV: begin strobe.fn = FN_SRA; strobe.varShift = 1'b1; end
          OP_AND:  strobe.fn = FN_AND;
          OP_OR:   strobe.fn = FN_OR;
          OP_XOR:  strobe.fn = FN_XOR;
          OP_NOR:  strobe.fn = FN_NOR;
          OP_SLT:  strobe.fn = FN_SLT;
          OP_SLTU: strobe.fn = FN_SLTU;
          OP_MULT: strobe.fn = FN_MULS;
          OP_MULTU: strobe.fn = FN_MULU;
          OP_DIV:  strobe.fn = FN_DIVS;
          OP_DIVU: strobe.fn = FN_DIVU;
          OP_JALR: strobe.fn = FN_LINK;
          default: strobe.fn = FN_ZERO;
        endcase
      end
      CLS_IMM: begin
        case (opSel)
          OPI_ADDI, OPI_ADDIU, OPI_LOAD: begin
            strobe.fn = FN_ADD; strobe.srcB = SB_SEXT;
          end
          OPI_STORE: begin
            strobe.fn = FN_ADD; strobe.srcA = SA_REGB; strobe.srcB = SB_SEXT;
          end
          OPI_SLTI:  begin strobe.fn = FN_SLT;  strobe.srcB = SB_SEXT; end
          OPI_SLTIU: begin strobe.fn = FN_SLTU; strobe.srcB = SB_ZEXT; end
          OPI_ANDI: begin strobe.fn = FN_AND; strobe.srcA = SA_LOWA; strobe.srcB = SB_ZEXT; end
          OPI_ORI:  begin strobe.fn = FN_OR;  strobe.srcA = SA_LOWA; strobe.srcB = SB_ZEXT; end
          OPI_XORI: begin strobe.fn = FN_XOR; strobe.srcA = SA_LOWA; strobe.srcB = SB_ZEXT; end
          OPI_LUI:  strobe.fn = FN_LUI;
          OPI_BEQ:  strobe.fn = FN_EQ;
          OPI_BNE:  strobe.fn = FN_NE;
          OPI_BLTZ: strobe.fn = FN_LTZ;
          default:  strobe.fn = FN_ZERO;
        endcase
      end
      CLS_JMP: begin
        if (opSel == OPJ_CALL) strobe.fn = FN_LINK;
      end
      default: strobe.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/exu_datapath.sv
module exu_datapath
  import exu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 16,
  parameter int SHAMT_W  = 5,
  parameter int LINK_INC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [SHAMT_W-1:0]  shamt,
  input  logic [IMM_W-1:0]    imm,
  input  logic [DATA_W-1:0]   pcIn,
  output logic                outValid,
  output logic [2*DATA_W-1:0] result,
  output logic                errFlag
);

  localparam int WIDE_W = 2 * DATA_W;
  localparam int PAD_W  = DATA_W - IMM_W;

  logic [DATA_W-1:0]        aVal, bVal, narrow;
  logic signed [DATA_W-1:0] aS, bS, qS, rS;
  logic [DATA_W-1:0]        qU, rU;
  logic signed [WIDE_W-1:0] aW, bW, prodS;
  logic [WIDE_W-1:0]        prodU, nextResult;
  logic [SHAMT_W-1:0]       shAmt;
  logic                     isWide, divZero;

  always_comb begin
    case (strobe.srcA)
      SA_REGB: aVal = opB;
      SA_LOWA: aVal = {{PAD_W{1'b0}}, opA[IMM_W-1:0]};
      default: aVal = opA;
    endcase
    case (strobe.srcB)
      SB_SEXT: bVal = {{PAD_W{imm[IMM_W-1]}}, imm};
      SB_ZEXT: bVal = {{PAD_W{1'b0}}, imm};
      default: bVal = opB;
    endcase
  end

  assign aS      = aVal;
  assign bS      = bVal;
  assign shAmt   = strobe.varShift ? opB[SHAMT_W-1:0] : shamt;
  assign divZero = (bVal == '0);

  // Full-width products
  assign aW    = {{DATA_W{aVal[DATA_W-1]}}, aVal};
  assign bW    = {{DATA_W{bVal[DATA_W-1]}}, bVal};
  assign prodS = aW * bW;
  assign prodU = {{DATA_W{1'b0}}, aVal} * {{DATA_W{1'b0}}, bVal};

  // Quotient and remainder, forced to zero on a zero divisor
  always_comb begin
    if (divZero) begin
      qS = '0; rS = '0; qU = '0; rU = '0;
    end else begin
      qS = aS / bS; rS = aS % bS;
      qU = aVal / bVal; rU = aVal % bVal;
    end
  end

  always_comb begin
    narrow = '0;
    isWide = 1'b0;
    case (strobe.fn)
      FN_ADD:  narrow = aVal + bVal;
      FN_SUB:  narrow = bVal - aVal;
      FN_SLL:  narrow = aVal << shAmt;
      FN_SRL:  narrow = aVal >> shAmt;
      FN_SRA:  narrow = aS >>> shAmt;
      FN_AND:  narrow = aVal & bVal;
      FN_OR:   narrow = aVal | bVal;
      FN_XOR:  narrow = aVal ^ bVal;
      FN_NOR:  narrow = ~(aVal | bVal);
      FN_SLT:  narrow = DATA_W'(aS < bS);
      FN_SLTU: narrow = DATA_W'(aVal < bVal);
      FN_LINK: narrow = pcIn + DATA_W'(LINK_INC);
      FN_LUI:  narrow = {imm, {PAD_W{1'b0}}};
      FN_EQ:   narrow = DATA_W'(aVal == bVal);
      FN_NE:   narrow = DATA_W'(aVal != bVal);
      FN_LTZ:  narrow = DATA_W'(aVal[DATA_W-1]);
      FN_MULS, FN_MULU, FN_DIVS, FN_DIVU: isWide = 1'b1;
      default: narrow = '0;
    endcase
  end

  always_comb begin
    case (strobe.fn)
      FN_MULS: nextResult = prodS;
      FN_MULU: nextResult = prodU;
      FN_DIVS: nextResult = {rS, qS};
      FN_DIVU: nextResult = {rU, qU};
      default: nextResult = {{DATA_W{1'b0}}, narrow};
    endcase
    if (!isWide) nextResult = {{DATA_W{1'b0}}, narrow};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      result   <= '0;
      errFlag  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result  <= nextResult;
        errFlag <= strobe.illegal;
      end
    end
  end

endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 16,
  parameter int SHAMT_W  = 5,
  parameter int LINK_INC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [1:0]          instrClass,
  input  logic [4:0]          opSel,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [SHAMT_W-1:0]  shamt,
  input  logic [IMM_W-1:0]    imm,
  input  logic [DATA_W-1:0]   pcIn,
  output logic                outValid,
  output logic [2*DATA_W-1:0] result,
  output logic                errFlag
);

  ctrlStrobe_t strobe;

  exu_ctrl ctrl_i (
    .instrClass (instrClass),
    .opSel      (opSel),
    .strobe     (strobe)
  );

  exu_datapath #(
    .DATA_W   (DATA_W),
    .IMM_W    (IMM_W),
    .SHAMT_W  (SHAMT_W),
    .LINK_INC (LINK_INC)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .shamt    (shamt),
    .imm      (imm),
    .pcIn     (pcIn),
    .outValid (outValid),
    .result   (result),
    .errFlag  (errFlag)
  );

endmodule

// File: rtl/exu_checker.sv
module exu_checker
  import exu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LINK_INC = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inValid,
  input logic [1:0]          instrClass,
  input logic [4:0]          opSel,
  input logic [DATA_W-1:0]   opB,
  input logic [DATA_W-1:0]   pcIn,
  input logic                outValid,
  input logic [2*DATA_W-1:0] result,
  input logic                errFlag
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(result) && $stable(errFlag)));

  a_r8_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && instrClass == CLS_REG && (opSel == OP_DIV || opSel == OP_DIVU) && opB == '0)
    |=> (result == '0));

  a_r11_flag_bool: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && instrClass == CLS_IMM &&
     (opSel == OPI_BEQ || opSel == OPI_BNE || opSel == OPI_BLTZ))
    |=> (result[2*DATA_W-1:1] == '0));

  a_r12_link: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && instrClass == CLS_JMP && opSel == OPJ_CALL)
    |=> (result == {{DATA_W{1'b0}}, $past(pcIn) + DATA_W'(LINK_INC)}));

  a_r13_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && instrClass == CLS_BAD) |=> (errFlag && result == '0));

  a_r13_good_class: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && instrClass != CLS_BAD) |=> !errFlag);

endmodule

bind exu_top exu_checker #(.DATA_W(DATA_W), .LINK_INC(LINK_INC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .inValid    (inValid),
  .instrClass (instrClass),
  .opSel      (opSel),
  .opB        (opB),
  .pcIn       (pcIn),
  .outValid   (outValid),
  .result     (result),
  .errFlag    (errFlag)
);

// File: tb/exu_top_tb_top.sv
module exu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  instrClass = 2'd0;
  logic [4:0]  opSel = 5'd0;
  logic [31:0] opA = 32'd0;
  logic [31:0] opB = 32'd0;
  logic [4:0]  shamt = 5'd0;
  logic [15:0] imm = 16'd0;
  logic [31:0] pcIn = 32'd0;
  logic        outValid;
  logic [63:0] result;
  logic        errFlag;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exu_top dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .instrClass(instrClass),
    .opSel(opSel), .opA(opA), .opB(opB), .shamt(shamt), .imm(imm),
    .pcIn(pcIn), .outValid(outValid), .result(result), .errFlag(errFlag)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one operation for one cycle; returns at the negedge after capture
  task automatic issue(input logic [1:0] c, input logic [4:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] sh, input logic [15:0] im,
                       input logic [31:0] pc);
    @(negedge clk);
    instrClass = c; opSel = o; opA = a; opB = b; shamt = sh; imm = im; pcIn = pc;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic run(input string tag, input logic [1:0] c, input logic [4:0] o,
                     input logic [31:0] a, input logic [31:0] b, input logic [4:0] sh,
                     input logic [15:0] im, input logic [31:0] pc, input logic [63:0] exp);
    issue(c, o, a, b, sh, im, pc);
    check({tag, " result"}, result, exp);
    check({tag, " outValid"}, {63'd0, outValid}, 64'd1);
  endtask

  task automatic t_reset;
    check("R1 reset outValid", {63'd0, outValid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    check("R1 reset errFlag", {63'd0, errFlag}, 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] keep;
    run("R1 setup", 2'd0, 5'd0, 32'd40, 32'd2, 5'd0, 16'd0, 32'd0, 64'd42);
    keep = result;
    @(negedge clk);
    check("R1 outValid drops", {63'd0, outValid}, 64'd0);
    check("R1 result held", result, keep);
  endtask

  task automatic t_addsub;
    run("R2 add wrap", 2'd0, 5'd0, 32'hFFFF_FFFF, 32'd2, 5'd0, 16'd0, 32'd0, 64'd1);
    check("R2 add no error", {63'd0, errFlag}, 64'd0);
    run("R2 addu wrap", 2'd0, 5'd1, 32'hFFFF_FFFF, 32'd2, 5'd0, 16'd0, 32'd0, 64'd1);
    run("R2 add signed overflow", 2'd0, 5'd0, 32'h7FFF_FFFF, 32'd1, 5'd0, 16'd0, 32'd0, 64'h8000_0000);
    check("R2 overflow no error", {63'd0, errFlag}, 64'd0);
    run("R2 sub", 2'd0, 5'd2, 32'd5, 32'd3, 5'd0, 16'd0, 32'd0, 64'h0000_0000_FFFF_FFFE);
    run("R2 subu", 2'd0, 5'd3, 32'd5, 32'd3, 5'd0, 16'd0, 32'd0, 64'h0000_0000_FFFF_FFFE);
  endtask

  task automatic t_shifts;
    run("R3 sll", 2'd0, 5'd4, 32'd1, 32'd0, 5'd4, 16'd0, 32'd0, 64'h10);
    run("R3 sllv", 2'd0, 5'd5, 32'd1, 32'h23, 5'd9, 16'd0, 32'd0, 64'h8);
    run("R4 srl zero fill", 2'd0, 5'd6, 32'h8000_0000, 32'd0, 5'd4, 16'd0, 32'd0, 64'h0800_0000);
    run("R4 srlv zero fill", 2'd0, 5'd7, 32'h8000_0000, 32'h24, 5'd0, 16'd0, 32'd0, 64'h0800_0000);
    run("R4 sra sign fill", 2'd0, 5'd8, 32'h8000_0000, 32'd0, 5'd4, 16'd0, 32'd0, 64'hF800_0000);
    run("R4 srav sign fill", 2'd0, 5'd9, 32'h8000_0000, 32'hFFFF_FFE4, 5'd1, 16'd0, 32'd0, 64'hF800_0000);
  endtask

  task automatic t_logic;
    run("R5 and", 2'd0, 5'd10, 32'hF0F0, 32'hFF00, 5'd0, 16'd0, 32'd0, 64'hF000);
    run("R5 or", 2'd0, 5'd11, 32'hF0F0, 32'hFF00, 5'd0, 16'd0, 32'd0, 64'hFFF0);
    run("R5 xor", 2'd0, 5'd12, 32'hF0F0, 32'hFF00, 5'd0, 16'd0, 32'd0, 64'h0FF0);
    run("R5 nor", 2'd0, 5'd13, 32'hF0F0, 32'hFF00, 5'd0, 16'd0, 32'd0, 64'hFFFF_000F);
  endtask

  task automatic t_compare;
    run("R6 slt signed", 2'd0, 5'd14, 32'hFFFF_FFFF, 32'd1, 5'd0, 16'd0, 32'd0, 64'd1);
    run("R6 sltu unsigned", 2'd0, 5'd15, 32'hFFFF_FFFF, 32'd1, 5'd0, 16'd0, 32'd0, 64'd0);
    run("R6 slti sext", 2'd1, 5'd2, 32'hFFFF_FFFB, 32'd0, 5'd0, 16'hFFFC, 32'd0, 64'd1);
    run("R6 sltiu zext true", 2'd1, 5'd3, 32'd5, 32'd0, 5'd0, 16'hFFFC, 32'd0, 64'd1);
    run("R6 sltiu zext false", 2'd1, 5'd3, 32'h0001_0000, 32'd0, 5'd0, 16'hFFFC, 32'd0, 64'd0);
  endtask

  task automatic t_muldiv;
    run("R7 mult signed", 2'd0, 5'd16, 32'hFFFF_FFFD, 32'd5, 5'd0, 16'd0, 32'd0, 64'hFFFF_FFFF_FFFF_FFF1);
    run("R7 multu", 2'd0, 5'd17, 32'hFFFF_FFFF, 32'd2, 5'd0, 16'd0, 32'd0, 64'h1_FFFF_FFFE);
    run("R8 div signed", 2'd0, 5'd18, 32'hFFFF_FFF9, 32'd2, 5'd0, 16'd0, 32'd0, 64'hFFFF_FFFF_FFFF_FFFD);
    run("R8 divu", 2'd0, 5'd19, 32'd7, 32'd2, 5'd0, 16'd0, 32'd0, 64'h1_0000_0003);
    run("R8 div by zero", 2'd0, 5'd18, 32'd9, 32'd0, 5'd0, 16'd0, 32'd0, 64'd0);
    run("R8 divu by zero", 2'd0, 5'd19, 32'd9, 32'd0, 5'd0, 16'd0, 32'd0, 64'd0);
  endtask

  task automatic t_immediate;
    run("R9 addi", 2'd1, 5'd0, 32'd10, 32'd0, 5'd0, 16'hFFFE, 32'd0, 64'd8);
    run("R9 addiu", 2'd1, 5'd1, 32'd10, 32'd0, 5'd0, 16'hFFFE, 32'd0, 64'd8);
    run("R9 load addr", 2'd1, 5'd8, 32'h1000, 32'h5555, 5'd0, 16'hFFF0, 32'd0, 64'h0FF0);
    run("R9 store addr", 2'd1, 5'd9, 32'hDEAD, 32'h2000, 5'd0, 16'h0004, 32'd0, 64'h2004);
    run("R10 andi", 2'd1, 5'd4, 32'h1234_F0F0, 32'd0, 5'd0, 16'hFF00, 32'd0, 64'hF000);
    run("R10 ori", 2'd1, 5'd5, 32'hFFFF_0001, 32'd0, 5'd0, 16'h0100, 32'd0, 64'h0101);
    run("R10 xori", 2'd1, 5'd6, 32'hABCD_00FF, 32'd0, 5'd0, 16'h0F0F, 32'd0, 64'h0FF0);
    run("R10 lui", 2'd1, 5'd7, 32'hFFFF_FFFF, 32'd0, 5'd0, 16'h1234, 32'd0, 64'h1234_0000);
  endtask

  task automatic t_branch;
    run("R11 beq equal", 2'd1, 5'd10, 32'd7, 32'd7, 5'd0, 16'd0, 32'd0, 64'd1);
    run("R11 beq differ", 2'd1, 5'd10, 32'd7, 32'd8, 5'd0, 16'd0, 32'd0, 64'd0);
    run("R11 bne differ", 2'd1, 5'd11, 32'd7, 32'd8, 5'd0, 16'd0, 32'd0, 64'd1);
    run("R11 bltz negative", 2'd1, 5'd12, 32'h8000_0000, 32'd0, 5'd0, 16'd0, 32'd0, 64'd1);
    run("R11 bltz zero", 2'd1, 5'd12, 32'd0, 32'd0, 5'd0, 16'd0, 32'd0, 64'd0);
  endtask

  task automatic t_link;
    run("R12 jal", 2'd2, 5'd0, 32'd0, 32'd0, 5'd0, 16'd0, 32'h0040_0000, 64'h0040_0002);
    run("R12 jal wrap", 2'd2, 5'd0, 32'd0, 32'd0, 5'd0, 16'd0, 32'hFFFF_FFFF, 64'd1);
    run("R12 jalr", 2'd0, 5'd20, 32'h55, 32'd0, 5'd0, 16'd0, 32'h0000_0100, 64'h102);
  endtask

  task automatic t_errors;
    run("R13 bad class", 2'd3, 5'd0, 32'd1, 32'd2, 5'd0, 16'd0, 32'd0, 64'd0);
    check("R13 bad class errFlag", {63'd0, errFlag}, 64'd1);
    run("R13 unlisted reg op", 2'd0, 5'd31, 32'd1, 32'd2, 5'd0, 16'd0, 32'd0, 64'd0);
    check("R13 unlisted clears errFlag", {63'd0, errFlag}, 64'd0);
    run("R13 unlisted jump op", 2'd2, 5'd3, 32'd0, 32'd0, 5'd0, 16'd0, 32'h100, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_hold();
    t_addsub();
    t_shifts();
    t_logic();
    t_compare();
    t_muldiv();
    t_immediate();
    t_branch();
    t_link();
    t_errors();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule